// File: doc/BRIEF.md
# Two-wire slave event and interrupt register unit

This unit is the software-facing control layer of a two-wire bus slave. It sits on a simple 32-bit register bus. Writes to a small set of task addresses become single-cycle command pulses for the slave engine. One-cycle event strobes coming back from the engine are caught in sticky flags that software can read and clear. The unit also holds the interrupt enables, the shortcut bits, the error-source flags, the captured match index and the enable field.

The interrupt enables can be reached through three addresses. One writes the enables directly, one sets the bits written as 1, and one clears them. All three read back the current enables. A single interrupt line is raised while any event flag is set and its enable bit is on. Two shortcut bits let an incoming read or write command produce a suspend pulse in hardware. Software can then look at the received data before the engine continues, with no interrupt latency in between.

Top module: `twis_evt_regs`

## Requirements
- R1: Writing a word whose bit 0 is 1 to a task address makes the matching `task_pulse` bit high for exactly the next cycle. The addresses and bits are 0x014 stop (bit 0), 0x01C suspend (bit 1), 0x020 resume (bit 2), 0x030 prepare-receive (bit 3) and 0x034 prepare-transmit (bit 4). A write with bit 0 at 0 gives no pulse. Task addresses read 0.
- R2: Each event strobe `evt_pulse[k]` sets a flag that reads back in bit 0 of its address. The strobes and addresses are k=0 stopped 0x104, k=1 error 0x124, k=2 receive-started 0x14C, k=3 transmit-started 0x150, k=4 write-command 0x164 and k=5 read-command 0x168. A bus write stores bit 0 of the data into the flag, so writing 0 clears it. A strobe in the same cycle as the write wins.
- R3: The enable bits for the six events sit at bits 1, 9, 19, 20, 25 and 26, for k=0..5 in order. Address 0x300 loads them directly, 0x304 sets each bit written as 1, and 0x308 clears each bit written as 1. All three addresses read the current enables, and every other bit reads 0.
- R4: `irq` is high exactly when some event flag is set and its enable bit is set.
- R5: The shortcut word is at 0x200. Bit 13 makes a write-command strobe raise the suspend pulse (`task_pulse[1]`) in the next cycle, and bit 14 does the same for a read-command strobe. All other bits read 0.
- R6: The error flags are at 0x4D0: bit 0 overflow (`err_set[0]`), bit 2 data-NACK (`err_set[1]`) and bit 3 over-read (`err_set[2]`). A strobe sets its flag. Writing 1 to a flag's bit clears it. A strobe in the same cycle as the clear wins.
- R7: Address 0x4D4 reads, in bit 0, the value `match_idx` had at the most recent read-command or write-command strobe. The value is unchanged at other times.
- R8: The enable field is at 0x500, bits 3:0. A write with 9 in that field makes `enabled` high from the next cycle, and the field reads 9. A write with any other value makes `enabled` low, and the field reads 0.
- R9: After reset, every register reads 0 and `task_pulse`, `irq` and `enabled` are low.
- R10: Addresses not listed above read 0, and writes to them change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Write strobe for the current address |
| reg_addr | input | ADDR_W | Byte address of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| evt_pulse | input | 6 | One-cycle event strobes from the slave engine |
| err_set | input | 3 | One-cycle error strobes: overflow, data-NACK, over-read |
| match_idx | input | 1 | Index of the address that matched on the current command |
| task_pulse | output | 5 | One-cycle task commands: stop, suspend, resume, prepare-rx, prepare-tx |
| irq | output | 1 | Interrupt request |
| enabled | output | 1 | Peripheral enabled |

## Verification
The bench targets the same-cycle collisions. It strobes an event while software writes 0 to that event, and it strobes an error while software writes 1 to clear it. A design with the priority backwards would lose a real event or error. The set and clear aliases are exercised with overlapping patterns and with bits outside the defined positions. A wrong alias would wipe enables it should keep, or store bits that must read 0. The bench also checks that each shortcut fires only for its own command strobe, that an enable value such as 5 or 0x19 is judged on its low four bits only, and that the match index moves only on a command strobe. Random traffic over every address is compared against the model on each cycle.

// File: rtl/twis_evt_regs.sv
module twis_evt_regs #(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic [5:0]        evt_pulse,
  input  logic [2:0]        err_set,
  input  logic              match_idx,
  output logic [4:0]        task_pulse,
  output logic              irq,
  output logic              enabled
);
  localparam int NTASK = 5;
  localparam int NEVT  = 6;
  localparam logic [ADDR_W-1:0] TASK_OFS [NTASK] = '{
    ADDR_W'(12'h014), ADDR_W'(12'h01C), ADDR_W'(12'h020), ADDR_W'(12'h030), ADDR_W'(12'h034)};
  localparam logic [ADDR_W-1:0] EV_OFS [NEVT] = '{
    ADDR_W'(12'h104), ADDR_W'(12'h124), ADDR_W'(12'h14C),
    ADDR_W'(12'h150), ADDR_W'(12'h164), ADDR_W'(12'h168)};
  localparam int IEN_POS [NEVT] = '{1, 9, 19, 20, 25, 26};
  localparam logic [31:0] IEN_MASK = (32'd1 << 1) | (32'd1 << 9) | (32'd1 << 19) |
                                     (32'd1 << 20) | (32'd1 << 25) | (32'd1 << 26);
  localparam logic [ADDR_W-1:0] OFS_SHORTS = ADDR_W'(12'h200);
  localparam logic [ADDR_W-1:0] OFS_IEN    = ADDR_W'(12'h300);
  localparam logic [ADDR_W-1:0] OFS_ISET   = ADDR_W'(12'h304);
  localparam logic [ADDR_W-1:0] OFS_ICLR   = ADDR_W'(12'h308);
  localparam logic [ADDR_W-1:0] OFS_ERR    = ADDR_W'(12'h4D0);
  localparam logic [ADDR_W-1:0] OFS_MATCH  = ADDR_W'(12'h4D4);
  localparam logic [ADDR_W-1:0] OFS_EN     = ADDR_W'(12'h500);
  localparam logic [3:0]        EN_ON      = 4'd9;

  logic [NEVT-1:0]  evf;
  logic [NEVT-1:0]  ev_en;
  logic [NTASK-1:0] task_req;
  logic [31:0]      inten;
  logic [1:0]       shorts;
  logic [2:0]       errsrc;
  logic [2:0]       err_clr;
  logic             match_q;
  logic [3:0]       enf;
  logic             short_hit;

  for (genvar t = 0; t < NTASK; t++) begin : g_task
    assign task_req[t] = reg_wr && reg_wdata[0] && (reg_addr == TASK_OFS[t]);
  end

  assign short_hit = (evt_pulse[4] && shorts[0]) || (evt_pulse[5] && shorts[1]);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) task_pulse <= '0;
    else        task_pulse <= task_req | (NTASK'(short_hit) << 1);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) evf <= '0;
    else
      for (int k = 0; k < NEVT; k++)
        if (evt_pulse[k])                          evf[k] <= 1'b1;
        else if (reg_wr && reg_addr == EV_OFS[k])  evf[k] <= reg_wdata[0];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) inten <= '0;
    else if (reg_wr && reg_addr == OFS_IEN)  inten <= reg_wdata & IEN_MASK;
    else if (reg_wr && reg_addr == OFS_ISET) inten <= inten | (reg_wdata & IEN_MASK);
    else if (reg_wr && reg_addr == OFS_ICLR) inten <= inten & ~reg_wdata;

  for (genvar k = 0; k < NEVT; k++) begin : g_ien
    assign ev_en[k] = inten[IEN_POS[k]];
  end
  assign irq = |(evf & ev_en);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) shorts <= '0;
    else if (reg_wr && reg_addr == OFS_SHORTS) shorts <= {reg_wdata[14], reg_wdata[13]};

  assign err_clr = (reg_wr && reg_addr == OFS_ERR) ? {reg_wdata[3], reg_wdata[2], reg_wdata[0]} : 3'b0;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) errsrc <= '0;
    else        errsrc <= (errsrc & ~err_clr) | err_set;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) match_q <= 1'b0;
    else if (evt_pulse[4] || evt_pulse[5]) match_q <= match_idx;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) enf <= '0;
    else if (reg_wr && reg_addr == OFS_EN) enf <= (reg_wdata[3:0] == EN_ON) ? EN_ON : 4'd0;

  assign enabled = (enf == EN_ON);

  always_comb begin
    reg_rdata = '0;
    for (int k = 0; k < NEVT; k++)
      if (reg_addr == EV_OFS[k]) reg_rdata = {31'b0, evf[k]};
    case (reg_addr)
      OFS_IEN, OFS_ISET, OFS_ICLR: reg_rdata = inten;
      OFS_SHORTS: reg_rdata = {17'b0, shorts, 13'b0};
      OFS_ERR:    reg_rdata = {28'b0, errsrc[2], errsrc[1], 1'b0, errsrc[0]};
      OFS_MATCH:  reg_rdata = {31'b0, match_q};
      OFS_EN:     reg_rdata = {28'b0, enf};
      default: ;
    endcase
  end
endmodule

// File: rtl/twis_evt_regs_chk.sv
module twis_evt_regs_chk #(
  parameter int ADDR_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [31:0]       reg_wdata,
  input logic [31:0]       reg_rdata,
  input logic [5:0]        evt_pulse,
  input logic [2:0]        err_set,
  input logic [4:0]        task_pulse,
  input logic              irq,
  input logic              enabled,
  input logic [5:0]        evf,
  input logic [2:0]        errsrc
);
  a_r1_stop_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == ADDR_W'(12'h014) && reg_wdata[0]) |=> task_pulse[0]);

  a_r2_event_sticks: assert property (@(posedge clk) disable iff (!rst_n)
    evt_pulse[0] |=> evf[0]);

  a_r4_irq_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == ADDR_W'(12'h300) && reg_rdata == 32'd0) |-> !irq);

  a_r5_read_shortcut: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == ADDR_W'(12'h200) && reg_rdata[14] && evt_pulse[5]) |=> task_pulse[1]);

  a_r6_set_beats_clear: assert property (@(posedge clk) disable iff (!rst_n)
    err_set[0] |=> errsrc[0]);

  a_r8_enable_view: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == ADDR_W'(12'h500)) |-> (reg_rdata[3:0] == (enabled ? 4'd9 : 4'd0)));
endmodule

bind twis_evt_regs twis_evt_regs_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/sim_twis_evt_regs.sv
module sim_twis_evt_regs;
  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_wr = 1'b0;
  logic [11:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [5:0] evt_pulse = '0;
  logic [2:0] err_set = '0;
  logic match_idx = 1'b0;
  logic [4:0] task_pulse;
  logic irq, enabled;

  int checks = 0, failures = 0;
  bit done = 0;

  always #4 clk = ~clk;

  twis_evt_regs #(.ADDR_W(12)) u0 (.*);

  // reference state
  bit [5:0]  m_evf;
  bit [31:0] m_ien;
  bit        m_s13, m_s14;
  bit [31:0] m_err;
  bit        m_match;
  bit [3:0]  m_en;
  bit [4:0]  m_task;
  int ev_ofs  [6] = '{'h104, 'h124, 'h14C, 'h150, 'h164, 'h168};
  int tk_ofs  [5] = '{'h014, 'h01C, 'h020, 'h030, 'h034};
  int ien_pos [6] = '{1, 9, 19, 20, 25, 26};
  int addr_pool [20] = '{'h014, 'h01C, 'h020, 'h030, 'h034, 'h104, 'h124, 'h14C, 'h150, 'h164,
                         'h168, 'h200, 'h300, 'h304, 'h308, 'h4D0, 'h4D4, 'h500, 'h400, 'h0F0};

  function automatic bit [31:0] ien_mask();
    bit [31:0] m = 0;
    foreach (ien_pos[i]) m[ien_pos[i]] = 1'b1;
    return m;
  endfunction

  function automatic bit [31:0] m_read(input int a);
    for (int k = 0; k < 6; k++) if (a == ev_ofs[k]) return {31'b0, m_evf[k]};
    if (a == 'h300 || a == 'h304 || a == 'h308) return m_ien;
    if (a == 'h200) return (32'(m_s13) << 13) | (32'(m_s14) << 14);
    if (a == 'h4D0) return m_err;
    if (a == 'h4D4) return {31'b0, m_match};
    if (a == 'h500) return {28'b0, m_en};
    return 32'd0;
  endfunction

  function automatic string rtag(input int a);
    for (int k = 0; k < 5; k++) if (a == tk_ofs[k]) return "R1";
    for (int k = 0; k < 6; k++) if (a == ev_ofs[k]) return "R2";
    if (a == 'h300 || a == 'h304 || a == 'h308) return "R3";
    if (a == 'h200) return "R5";
    if (a == 'h4D0) return "R6";
    if (a == 'h4D4) return "R7";
    if (a == 'h500) return "R8";
    return "R10";
  endfunction

  function automatic bit m_irq();
    for (int k = 0; k < 6; k++) if (m_evf[k] && m_ien[ien_pos[k]]) return 1'b1;
    return 1'b0;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s t=%0t actual=%h expected=%h", tag, $time, act, exp);
    end
  endtask

  task automatic model_step(input bit w, input int a, input bit [31:0] d,
                            input bit [5:0] e, input bit [2:0] es, input bit mi);
    bit [31:0] clr;
    m_task = 0;
    for (int t = 0; t < 5; t++) if (w && d[0] && a == tk_ofs[t]) m_task[t] = 1'b1;
    if ((e[4] && m_s13) || (e[5] && m_s14)) m_task[1] = 1'b1;
    for (int k = 0; k < 6; k++)
      if (e[k]) m_evf[k] = 1'b1;
      else if (w && a == ev_ofs[k]) m_evf[k] = d[0];
    if (w && a == 'h300) m_ien = d & ien_mask();
    if (w && a == 'h304) m_ien = m_ien | (d & ien_mask());
    if (w && a == 'h308) m_ien = m_ien & ~d;
    if (w && a == 'h200) begin m_s13 = d[13]; m_s14 = d[14]; end
    clr = (w && a == 'h4D0) ? (d & 32'hD) : 32'd0;
    m_err = (m_err & ~clr) | {28'b0, es[2], es[1], 1'b0, es[0]};
    if (e[4] || e[5]) m_match = mi;
    if (w && a == 'h500) m_en = (d[3:0] == 4'd9) ? 4'd9 : 4'd0;
  endtask

  task automatic cyc(input bit w, input int a, input bit [31:0] d,
                     input bit [5:0] e, input bit [2:0] es, input bit mi);
    reg_wr = w; reg_addr = 12'(a); reg_wdata = d; evt_pulse = e; err_set = es; match_idx = mi;
    #1;
    chk(reg_rdata === m_read(a), rtag(a), reg_rdata, m_read(a));
    @(posedge clk);
    model_step(w, a, d, e, es, mi);
    @(negedge clk);
    chk(task_pulse === m_task, "R1 R5 task pulse", 32'(task_pulse), 32'(m_task));
    chk(irq === m_irq(), "R4 irq", 32'(irq), 32'(m_irq()));
    chk(enabled === (m_en == 4'd9), "R8 enabled", 32'(enabled), 32'(m_en == 4'd9));
  endtask

  task automatic wr(input int a, input bit [31:0] d); cyc(1, a, d, 0, 0, 0); endtask
  task automatic rd(input int a); cyc(0, a, 0, 0, 0, 0); endtask
  task automatic ev(input bit [5:0] e, input bit mi); cyc(0, 'h4D4, 0, e, 0, mi); endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      failures++; checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9: reset state
    chk(task_pulse === 0 && irq === 0 && enabled === 0, "R9 outputs in reset",
        {task_pulse, irq, enabled}, 0);
    foreach (addr_pool[i]) begin
      reg_addr = 12'(addr_pool[i]); #1;
      chk(reg_rdata === 0, "R9 read in reset", reg_rdata, 0);
    end
    rst_n = 1'b1;
    @(negedge clk);
    foreach (addr_pool[i]) rd(addr_pool[i]);
    // R1: each task, and bit0=0 gives nothing
    foreach (tk_ofs[t]) begin wr(tk_ofs[t], 32'h1); rd(tk_ofs[t]); end
    wr('h014, 32'hFFFF_FFFE);
    wr('h034, 32'h3);
    // R2: each event sets; write 0 clears; strobe beats a clearing write
    for (int k = 0; k < 6; k++) begin ev(6'(1 << k), 0); rd(ev_ofs[k]); end
    wr('h124, 0); rd('h124);
    wr('h104, 0); rd('h104);
    cyc(1, 'h150, 0, 6'b001000, 0, 0); rd('h150);
    // R3 / R4: aliases and interrupt
    wr('h300, 32'hFFFF_FFFF); rd('h304); rd('h308);
    wr('h308, 32'h0200_0002); rd('h300);
    wr('h308, 32'hFFFF_FFFF);
    wr('h304, 32'h0000_0200); rd('h300);
    wr('h304, 32'h0600_0000); rd('h308);
    for (int k = 0; k < 6; k++) wr(ev_ofs[k], 0);
    ev(6'b000010, 0);
    wr('h308, 32'h0000_0200);
    wr('h304, 32'h0000_0002);
    ev(6'b000001, 0);
    wr('h104, 0); wr('h124, 0);
    // R5: shortcuts
    ev(6'b110000, 0);
    wr('h200, 32'h0000_2000); rd('h200);
    ev(6'b010000, 0);
    ev(6'b100000, 1);
    wr('h200, 32'hFFFF_BFFF); rd('h200);
    ev(6'b100000, 0);
    ev(6'b010000, 0);
    wr('h200, 0);
    // R6: error source
    cyc(0, 'h4D0, 0, 0, 3'b111, 0); rd('h4D0);
    wr('h4D0, 32'h0000_0004); rd('h4D0);
    cyc(1, 'h4D0, 32'hFFFF_FFFF, 0, 3'b001, 0); rd('h4D0);
    wr('h4D0, 32'hF);
    // R7: match capture
    ev(6'b010000, 1); rd('h4D4);
    cyc(0, 'h4D4, 0, 0, 0, 0); rd('h4D4);
    ev(6'b100000, 0); rd('h4D4);
    wr('h4D4, 32'h1); rd('h4D4);
    // R8: enable field
    wr('h500, 9); rd('h500);
    wr('h500, 5); rd('h500);
    wr('h500, 32'h19); rd('h500);
    wr('h500, 0); rd('h500);
    // R10: unmapped
    wr('h400, 32'hFFFF_FFFF); rd('h400);
    wr('h0F0, 32'h1); rd('h0F0);
    // mixed traffic
    for (int n = 0; n < 1500; n++) begin
      int a;
      a = addr_pool[$urandom % 20];
      cyc(($urandom % 3) == 0, a, $urandom, 6'($urandom % 4 == 0 ? $urandom : 0),
          3'($urandom % 5 == 0 ? $urandom : 0), 1'($urandom));
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule